// File: doc/BRIEF.md
# Low-Power Mode Entry Sequencer

This block takes the chip from normal operation into one of three low-power modes once the processor signals that it is waiting for an interrupt. Software first writes a two-bit mode field. When the wait-for-interrupt trigger is seen with a mode other than NORMAL, the block stores that mode and starts a fixed chain of handshakes. It asks the AHB controller to go idle, then the AXI domain, then the external memory controllers to enter self-refresh. Each step waits for its acknowledge, however long that takes.

After the drains, the block runs a short tail of single-cycle power actions that depends on the mode. The system clock is moved from the PLL to the crystal oscillator, but only when the PLL is the current source. DEEP-STOP then turns off power gating. All modes then stop the PLL and the oscillator. SLEEP then drops the external regulator enable. A done flag marks completion and stays set until reset, which stands in for wake-up. Every output is a plain level: there is no streaming data path, so there is no valid/ready interface.

Top module: `lpm_entry_seq`

## Requirements
- R1: While reset is active and right after it, all three request outputs and `lpm_done` are 0, `clk_sel_osc` is 0 (PLL selected), and `pll_en`, `osc_en`, `pwr_gate_en` and `regulator_on` are 1.
- R2: The mode field encodes 0 = NORMAL, 1 = STOP, 2 = DEEP-STOP and 3 = SLEEP. With NORMAL, a high `standby_wfi` starts nothing: no request asserts and no power output changes.
- R3: If `standby_wfi` is high and the mode is not NORMAL at a rising edge while the block is idle, `ahb_idle_req` is high in the cycle after that edge.
- R4: Each request stays high, with no timeout, until its acknowledge is sampled high at a rising edge. It is low in the cycle after that edge.
- R5: The requests follow the order AHB, AXI, memory self-refresh. Each one rises in the same cycle that the previous one falls, and at most one is high at any time.
- R6: In the cycle after the memory acknowledge is sampled, the block samples `pll_is_source`. If it is 1, `clk_sel_osc` goes to 1 in the following cycle. If it is 0, `clk_sel_osc` stays 0.
- R7: In DEEP-STOP only, `pwr_gate_en` falls one cycle after the clock-switch step and before the clock sources stop. In the other modes it stays 1.
- R8: In every entry mode, `pll_en` and `osc_en` fall together in one cycle. This is the step after the clock switch, or after the power-gate step in DEEP-STOP.
- R9: In SLEEP only, `regulator_on` falls one cycle after the clock sources stop. In the other modes it stays 1.
- R10: `lpm_done` rises together with the final power action of the chosen mode. It then stays high until reset, and further triggers have no effect.
- R11: The mode is captured at the trigger edge. Changing the mode field during the sequence does not change which tail actions run.
- R12: An acknowledge that arrives while its own request is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; release models wake-up |
| pwr_mode_cfg | input | 2 | Target low-power mode field |
| standby_wfi | input | 1 | Processor wait-for-interrupt trigger |
| pll_is_source | input | 1 | High when the PLL currently drives the system clock |
| ahb_idle_req | output | 1 | Request to the AHB controller to finish its transfer |
| ahb_idle_ack | input | 1 | AHB controller has finished |
| axi_idle_req | output | 1 | Request to the AXI domain to finish its transfer |
| axi_idle_ack | input | 1 | AXI domain has finished |
| mem_sr_req | output | 1 | Request to the memory controllers to enter self-refresh |
| mem_sr_ack | input | 1 | Memory controllers are in self-refresh |
| clk_sel_osc | output | 1 | Clock select: 0 = PLL, 1 = crystal oscillator |
| pll_en | output | 1 | PLL enable |
| osc_en | output | 1 | Crystal oscillator enable |
| pwr_gate_en | output | 1 | Power-gating circuit enable |
| regulator_on | output | 1 | External regulator enable, active high |
| lpm_done | output | 1 | Entry sequence complete, held until reset |

## Verification
A wrong step state shows at the ports in the very next cycle. Every request and `lpm_done` is decoded straight from a register, so a skipped or repeated drain appears as a request rising early, twice, or next to another one. A mode captured wrongly changes which tail outputs fall and in what order, and this is visible within the three cycles after the memory acknowledge. A missed acknowledge leaves its request stuck high. An accepted stray acknowledge moves a later request forward. The bench runs a cycle-accurate model and compares it with the design every clock, so any of these faults is caught in the cycle it first shows.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int MODE_W       = 2;
  localparam int DRAIN_STAGES = 3;

  typedef enum logic [MODE_W-1:0] {
    LPM_NORMAL = 2'd0,
    LPM_STOP   = 2'd1,
    LPM_DEEP   = 2'd2,
    LPM_SLEEP  = 2'd3
  } lpm_mode_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DRAIN,
    PH_CLKSW,
    PH_PGATE,
    PH_SRCOFF,
    PH_REGOFF,
    PH_DONE
  } lpm_phase_e;
endpackage

// File: rtl/lpm_drain_stage.sv
module lpm_drain_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic ack,
  output logic req,
  output logic finished
);
  logic busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              busy_q <= 1'b0;
    else if (start)          busy_q <= 1'b1;
    else if (busy_q && ack)  busy_q <= 1'b0;
  end

  assign req      = busy_q;
  assign finished = busy_q & ack;

  // R4: a pending request is never withdrawn without its acknowledge
  assert_req_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ack) |=> req);

  // R4: request drops the cycle after its acknowledge
  assert_req_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req && ack && !start) |=> !req);
endmodule

// File: rtl/lpm_drain_chain.sv
module lpm_drain_chain #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [N-1:0] ack,
  output logic [N-1:0] req,
  output logic         all_done
);
  logic [N-1:0] fin;
  logic [N-1:0] kick;

  for (genvar i = 0; i < N; i++) begin : g_stage
    if (i == 0) begin : g_head
      assign kick[i] = start;
    end else begin : g_link
      assign kick[i] = fin[i-1];
    end
    lpm_drain_stage u_stage (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (kick[i]),
      .ack      (ack[i]),
      .req      (req[i]),
      .finished (fin[i])
    );
  end

  assign all_done = fin[N-1];

  // R5: requests are mutually exclusive
  assert_one_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req));

  // R12: an acknowledge with no pending request leaves the requests untouched
  assert_stray_ack_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0 && !start) |=> (req == '0));
endmodule

// File: rtl/lpm_tail_ctrl.sv
module lpm_tail_ctrl
  import lpm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_cfg,
  input  logic              wfi,
  input  logic              drain_done,
  input  logic              pll_active,
  output logic              drain_start,
  output logic              clk_sel_osc,
  output logic              pll_en,
  output logic              osc_en,
  output logic              pgate_en,
  output logic              reg_on,
  output logic              done
);
  lpm_phase_e phase_q, phase_d;
  lpm_mode_e  mode_q;
  logic       entry_ok;

  assign entry_ok    = wfi && (lpm_mode_e'(mode_cfg) != LPM_NORMAL);
  assign drain_start = (phase_q == PH_IDLE) && entry_ok;
  assign done        = (phase_q == PH_DONE);

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:   if (entry_ok)   phase_d = PH_DRAIN;
      PH_DRAIN:  if (drain_done) phase_d = PH_CLKSW;
      PH_CLKSW:  phase_d = (mode_q == LPM_DEEP) ? PH_PGATE : PH_SRCOFF;
      PH_PGATE:  phase_d = PH_SRCOFF;
      PH_SRCOFF: phase_d = (mode_q == LPM_SLEEP) ? PH_REGOFF : PH_DONE;
      PH_REGOFF: phase_d = PH_DONE;
      PH_DONE:   phase_d = PH_DONE;
      default:   phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q     <= PH_IDLE;
      mode_q      <= LPM_NORMAL;
      clk_sel_osc <= 1'b0;
      pll_en      <= 1'b1;
      osc_en      <= 1'b1;
      pgate_en    <= 1'b1;
      reg_on      <= 1'b1;
    end else begin
      phase_q <= phase_d;
      if (drain_start) mode_q <= lpm_mode_e'(mode_cfg);
      if (phase_q == PH_CLKSW && pll_active) clk_sel_osc <= 1'b1;
      if (phase_q == PH_PGATE) pgate_en <= 1'b0;
      if (phase_q == PH_SRCOFF) begin
        pll_en <= 1'b0;
        osc_en <= 1'b0;
      end
      if (phase_q == PH_REGOFF) reg_on <= 1'b0;
    end
  end

  // R2: NORMAL never leaves idle
  assert_normal_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IDLE && lpm_mode_e'(mode_cfg) == LPM_NORMAL) |=> (phase_q == PH_IDLE));
  // R6: oscillator is selected only when the PLL was the source
  assert_clk_switch_cond_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_sel_osc) |-> $past(pll_active));
  // R7: power gating off only in DEEP-STOP, with clock sources still running
  assert_pgate_deep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pgate_en) |-> (mode_q == LPM_DEEP && pll_en && osc_en));
  // R8: both clock sources stop in the same cycle
  assert_src_together_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pll_en) |-> $fell(osc_en));
  // R9: regulator drops only in SLEEP, after the sources are off
  assert_reg_sleep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reg_on) |-> (mode_q == LPM_SLEEP && !pll_en));
  // R10: completion is sticky
  assert_done_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
  // R11: captured mode does not move once the sequence runs
  assert_mode_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE) |=> $stable(mode_q));
endmodule

// File: rtl/lpm_entry_seq.sv
module lpm_entry_seq
  import lpm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] pwr_mode_cfg,
  input  logic              standby_wfi,
  input  logic              pll_is_source,
  output logic              ahb_idle_req,
  input  logic              ahb_idle_ack,
  output logic              axi_idle_req,
  input  logic              axi_idle_ack,
  output logic              mem_sr_req,
  input  logic              mem_sr_ack,
  output logic              clk_sel_osc,
  output logic              pll_en,
  output logic              osc_en,
  output logic              pwr_gate_en,
  output logic              regulator_on,
  output logic              lpm_done
);
  logic [DRAIN_STAGES-1:0] ack_vec;
  logic [DRAIN_STAGES-1:0] req_vec;
  logic                    drain_start;
  logic                    drain_done;

  // Stage order is behaviour: index 0 drains first
  assign ack_vec      = {mem_sr_ack, axi_idle_ack, ahb_idle_ack};
  assign ahb_idle_req = req_vec[0];
  assign axi_idle_req = req_vec[1];
  assign mem_sr_req   = req_vec[2];

  lpm_drain_chain #(.N(DRAIN_STAGES)) u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (drain_start),
    .ack      (ack_vec),
    .req      (req_vec),
    .all_done (drain_done)
  );

  lpm_tail_ctrl u_tail (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_cfg    (pwr_mode_cfg),
    .wfi         (standby_wfi),
    .drain_done  (drain_done),
    .pll_active  (pll_is_source),
    .drain_start (drain_start),
    .clk_sel_osc (clk_sel_osc),
    .pll_en      (pll_en),
    .osc_en      (osc_en),
    .pgate_en    (pwr_gate_en),
    .reg_on      (regulator_on),
    .done        (lpm_done)
  );

  // R5: AXI request only starts as the AHB request ends
  assert_axi_after_ahb_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(axi_idle_req) |-> $fell(ahb_idle_req));
  // R5: self-refresh request only starts as the AXI request ends
  assert_mem_after_axi_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_sr_req) |-> $fell(axi_idle_req));
  // R3: the AHB request is the first visible action of a sequence
  assert_ahb_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ahb_idle_req) |-> (pll_en && !lpm_done && !clk_sel_osc));
  // R6: clock switch only after the memory is in self-refresh
  assert_clk_after_mem_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_sel_osc) |-> (!mem_sr_req && !ahb_idle_req && !axi_idle_req));
endmodule

// File: tb/lpm_entry_seq_bench.sv
module lpm_entry_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] pwr_mode_cfg = 2'd0;
  logic       standby_wfi = 1'b0;
  logic       pll_is_source = 1'b1;
  logic       ahb_idle_ack = 1'b0, axi_idle_ack = 1'b0, mem_sr_ack = 1'b0;
  logic       ahb_idle_req, axi_idle_req, mem_sr_req;
  logic       clk_sel_osc, pll_en, osc_en, pwr_gate_en, regulator_on, lpm_done;

  int checks = 0;
  int errors = 0;
  bit cmp_en = 1'b0;

  always #4 clk = ~clk;

  lpm_entry_seq u_lpm_entry_seq (
    .clk(clk), .rst_n(rst_n), .pwr_mode_cfg(pwr_mode_cfg), .standby_wfi(standby_wfi),
    .pll_is_source(pll_is_source),
    .ahb_idle_req(ahb_idle_req), .ahb_idle_ack(ahb_idle_ack),
    .axi_idle_req(axi_idle_req), .axi_idle_ack(axi_idle_ack),
    .mem_sr_req(mem_sr_req), .mem_sr_ack(mem_sr_ack),
    .clk_sel_osc(clk_sel_osc), .pll_en(pll_en), .osc_en(osc_en),
    .pwr_gate_en(pwr_gate_en), .regulator_on(regulator_on), .lpm_done(lpm_done)
  );

  // Behavioural reference: step counter 0 idle, 1..3 drains, 4 clock switch,
  // 5 gate off, 6 sources off, 7 regulator off, 8 finished
  int step = 0;
  int held_mode = 0;
  bit e_sel = 0, e_pll = 1, e_osc = 1, e_pg = 1, e_reg = 1;

  always @(posedge clk) begin
    if (!rst_n) begin
      step = 0; held_mode = 0;
      e_sel = 0; e_pll = 1; e_osc = 1; e_pg = 1; e_reg = 1;
    end else begin
      case (step)
        0: if (standby_wfi && pwr_mode_cfg != 2'd0) begin held_mode = pwr_mode_cfg; step = 1; end
        1: if (ahb_idle_ack) step = 2;
        2: if (axi_idle_ack) step = 3;
        3: if (mem_sr_ack) step = 4;
        4: begin if (pll_is_source) e_sel = 1; step = (held_mode == 2) ? 5 : 6; end
        5: begin e_pg = 0; step = 6; end
        6: begin e_pll = 0; e_osc = 0; step = (held_mode == 3) ? 7 : 8; end
        7: begin e_reg = 0; step = 8; end
        default: step = 8;
      endcase
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en) begin
      chk("R5 ahb_idle_req", ahb_idle_req, step == 1);
      chk("R5 axi_idle_req", axi_idle_req, step == 2);
      chk("R5 mem_sr_req",   mem_sr_req,   step == 3);
      chk("R6 clk_sel_osc",  clk_sel_osc,  e_sel);
      chk("R7 pwr_gate_en",  pwr_gate_en,  e_pg);
      chk("R8 pll_en",       pll_en,       e_pll);
      chk("R8 osc_en",       osc_en,       e_osc);
      chk("R9 regulator_on", regulator_on, e_reg);
      chk("R10 lpm_done",    lpm_done,     step == 8);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    cmp_en = 0;
    rst_n = 0; standby_wfi = 0;
    ahb_idle_ack = 0; axi_idle_ack = 0; mem_sr_ack = 0;
    cyc(3);
    rst_n = 1;
    cmp_en = 1;
  endtask

  function automatic logic req_of(input int which);
    case (which)
      0: return ahb_idle_req;
      1: return axi_idle_req;
      default: return mem_sr_req;
    endcase
  endfunction

  task automatic set_ack(input int which, input logic v);
    case (which)
      0: ahb_idle_ack = v;
      1: axi_idle_ack = v;
      default: mem_sr_ack = v;
    endcase
  endtask

  task automatic give_ack(input int which, input int delay);
    while (!req_of(which)) @(negedge clk);
    cyc(delay);
    set_ack(which, 1'b1);
    @(negedge clk);
    set_ack(which, 1'b0);
  endtask

  task automatic trigger(input logic [1:0] m);
    pwr_mode_cfg = m; standby_wfi = 1;
    @(negedge clk);
    standby_wfi = 0;
  endtask

  task automatic run_tail(input int n);
    cyc(n);
  endtask

  initial begin
    do_reset();
    // R1: reset values
    chk("R1 ahb_idle_req", ahb_idle_req, 0);
    chk("R1 mem_sr_req", mem_sr_req, 0);
    chk("R1 lpm_done", lpm_done, 0);
    chk("R1 clk_sel_osc", clk_sel_osc, 0);
    chk("R1 pll_en", pll_en, 1);
    chk("R1 osc_en", osc_en, 1);
    chk("R1 pwr_gate_en", pwr_gate_en, 1);
    chk("R1 regulator_on", regulator_on, 1);

    // R2: NORMAL mode with trigger held high does nothing
    pwr_mode_cfg = 2'd0; standby_wfi = 1;
    cyc(6);
    chk("R2 ahb_idle_req", ahb_idle_req, 0);
    chk("R2 pll_en", pll_en, 1);
    standby_wfi = 0;

    // STOP, PLL is the source, slow AHB, stray acks
    pll_is_source = 1;
    trigger(2'd1);
    chk("R3 ahb_idle_req", ahb_idle_req, 1);
    axi_idle_ack = 1; mem_sr_ack = 1;
    @(negedge clk);
    axi_idle_ack = 0; mem_sr_ack = 0;
    chk("R12 axi_idle_req", axi_idle_req, 0);
    chk("R12 mem_sr_req", mem_sr_req, 0);
    cyc(5);
    chk("R4 ahb_idle_req held", ahb_idle_req, 1);
    give_ack(0, 0);
    chk("R4 ahb_idle_req released", ahb_idle_req, 0);
    give_ack(1, 3);
    give_ack(2, 1);
    run_tail(4);
    chk("R6 clk_sel_osc", clk_sel_osc, 1);
    chk("R7 pwr_gate_en STOP", pwr_gate_en, 1);
    chk("R8 pll_en STOP", pll_en, 0);
    chk("R9 regulator_on STOP", regulator_on, 1);
    chk("R10 lpm_done", lpm_done, 1);
    trigger(2'd3);
    cyc(3);
    chk("R10 retrigger ignored", ahb_idle_req, 0);
    chk("R10 done held", lpm_done, 1);

    // DEEP-STOP, oscillator already the source
    do_reset();
    pll_is_source = 0;
    trigger(2'd2);
    give_ack(0, 2);
    give_ack(1, 0);
    give_ack(2, 4);
    run_tail(5);
    chk("R6 clk_sel_osc stays PLL", clk_sel_osc, 0);
    chk("R7 pwr_gate_en DEEP", pwr_gate_en, 0);
    chk("R8 osc_en DEEP", osc_en, 0);
    chk("R9 regulator_on DEEP", regulator_on, 1);

    // SLEEP, mode field changed mid-sequence
    do_reset();
    pll_is_source = 1;
    trigger(2'd3);
    pwr_mode_cfg = 2'd2;
    give_ack(0, 1);
    pwr_mode_cfg = 2'd0;
    give_ack(1, 1);
    give_ack(2, 0);
    run_tail(6);
    chk("R11 pwr_gate_en untouched", pwr_gate_en, 1);
    chk("R9 regulator_on SLEEP", regulator_on, 0);
    chk("R10 lpm_done SLEEP", lpm_done, 1);

    cyc(2);
    cmp_en = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule